// File: doc/BRIEF.md
# Chainable Two-Channel 8-Bit Timer

This block holds two 8-bit up-counters, a high channel and a low channel. Each has two compare values, three event flags (compare A, compare B, wrap), and an output pin that a 2-bit action code updates on each compare event. Each channel normally advances on one of six prescaled clock-enable strobes, picked by its 3-bit clock-select field. Select code 000 stops the channel.

The select code 100 chains the pair. On the high channel it makes the two counters one 16-bit counter, with the high channel as the upper byte and the low channel as the lower byte. On the low channel alone, the low channel instead counts the high channel's compare-A events. All state is reached through a simple write port and a read port with one cycle of read latency.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both counters, flags, pins and control fields read 0, and all four compare registers read 0xFF.
- R2: With no chaining, select 000 stops a channel. Codes 001, 010 and 011 pick tick_i[0], [1] and [2]. Codes 101, 110 and 111 pick tick_i[3], [4] and [5]. The counter adds 1 on each clock edge where the picked strobe is high.
- R3: A channel's wrap flag (status bit 2) is set on the edge where its counter advances from 0xFF to 0x00.
- R4: A compare event occurs when the counter advances into a value equal to a compare register. Compare A sets status bit 0 and compare B sets status bit 1. Each event applies its 2-bit action to the pin (00 keep, 01 low, 10 high, 11 toggle). Compare A uses control bits 4:3 and compare B uses bits 6:5. When both events occur on one edge, the B action is applied last and decides the result.
- R5: Writing the status register clears each flag whose written bit is 0 and leaves flags whose bit is 1. A flag-setting event on the same edge wins over the clear.
- R6: A counter write loads the value on the next edge and suppresses that edge's increment.
- R7: High-channel select 100 gives 16-bit mode. The low byte counts with its own select, and the high byte advances only on the edge where the low byte wraps.
- R8: In 16-bit mode the high channel's compare flags are set only when all 16 bits match the concatenated compare pair {high, low}. The low channel's flags are set on low-byte matches.
- R9: In 16-bit mode the high channel's wrap flag is set when the combined count goes from 0xFFFF to 0x0000.
- R10: A low-channel select of 100, with the high select not 100, makes the low counter advance exactly once per high-channel compare-A event, on the same edge.
- R11: In 16-bit mode the high pin acts on 16-bit compare events and the low pin acts on low-byte events.
- R12: Address bit 3 selects the channel (0 high, 1 low). Bits 2:0 select control (0), status (1), counter (2), compare A (3) and compare B (4). Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | W | Registered read data |
| tick_i | input | NTICK | Prescaled clock-enable strobes |
| tmo_hi | output | 1 | High-channel timer output |
| tmo_lo | output | 1 | Low-channel timer output |

## Verification
The properties assume that each strobe in tick_i is a single-cycle enable sampled on the rising edge. They also assume that the write port touches at most one register per cycle, so a counter load and a control change never overlap in ways the step properties ignore. The bench holds every strobe low except inside a pulse task that raises exactly one strobe for a known number of edges. It changes mode only while all strobes are low, so each expected count follows from counting edges. Two scenarios deliberately combine a write and a strobe on one edge, to exercise load suppression and set-over-clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_STOP  = 3'b000;
  localparam logic [SEL_W-1:0] SEL_CHAIN = 3'b100;

  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_STAT = 3'd1;
  localparam logic [2:0] IDX_CNT  = 3'd2;
  localparam logic [2:0] IDX_CMPA = 3'd3;
  localparam logic [2:0] IDX_CMPB = 3'd4;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE  = 2'd1,
    MODE_CMCNT = 2'd2
  } mode_e;

  function automatic logic pin_step(input logic cur, input act_e a);
    case (a)
      ACT_LOW:  pin_step = 1'b0;
      ACT_HIGH: pin_step = 1'b1;
      ACT_TOG:  pin_step = ~cur;
      default:  pin_step = cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_tick_pick.sv
module tmr_tick_pick import tmr_pkg::*; #(
  parameter int NTICK = 6
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NTICK-1:0] ticks,
  output logic             tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NTICK; i++) begin
      if (sel == ((i < 3) ? SEL_W'(i + 1) : SEL_W'(i + 2)))
        tick = ticks[i];
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [2:0]       rd_idx,
  input  logic             inc_i,
  input  logic             wide_i,
  input  logic             wide_ma_i,
  input  logic             wide_mb_i,
  output logic [W-1:0]     cnt_o,
  output logic [W-1:0]     cmpa_o,
  output logic [W-1:0]     cmpb_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             pin_o,
  output logic [W-1:0]     rd_data_o
);
  logic [W-1:0]     cnt_q, cmpa_q, cmpb_q, cnt_nxt;
  logic [SEL_W-1:0] sel_q;
  act_e             acta_q, actb_q;
  logic             fa_q, fb_q, ovf_q, pin_q;
  logic             cnt_wr, stat_wr, adv, full, ma_evt, mb_evt, ovf_evt;

  assign cnt_wr  = wr_en && (wr_idx == IDX_CNT);
  assign stat_wr = wr_en && (wr_idx == IDX_STAT);
  assign adv     = inc_i && !cnt_wr;
  assign full    = &cnt_q;
  assign cnt_nxt = W'(cnt_q + 1'b1);
  assign ma_evt  = wide_i ? wide_ma_i : (adv && (cnt_nxt == cmpa_q));
  assign mb_evt  = wide_i ? wide_mb_i : (adv && (cnt_nxt == cmpb_q));
  assign ovf_evt = adv && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cmpa_q <= '1;
      cmpb_q <= '1;
      sel_q  <= SEL_STOP;
      acta_q <= ACT_KEEP;
      actb_q <= ACT_KEEP;
      fa_q   <= 1'b0;
      fb_q   <= 1'b0;
      ovf_q  <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (cnt_wr)   cnt_q <= wr_data;
      else if (adv) cnt_q <= cnt_nxt;
      if (wr_en && wr_idx == IDX_CMPA) cmpa_q <= wr_data;
      if (wr_en && wr_idx == IDX_CMPB) cmpb_q <= wr_data;
      if (wr_en && wr_idx == IDX_CTRL) begin
        sel_q  <= wr_data[2:0];
        acta_q <= act_e'(wr_data[4:3]);
        actb_q <= act_e'(wr_data[6:5]);
      end
      fa_q  <= ma_evt  | (fa_q  & ~(stat_wr & ~wr_data[0]));
      fb_q  <= mb_evt  | (fb_q  & ~(stat_wr & ~wr_data[1]));
      ovf_q <= ovf_evt | (ovf_q & ~(stat_wr & ~wr_data[2]));
      pin_q <= pin_step(pin_step(pin_q, ma_evt ? acta_q : ACT_KEEP),
                        mb_evt ? actb_q : ACT_KEEP);
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_idx)
      IDX_CTRL: begin
        rd_data_o[2:0] = sel_q;
        rd_data_o[4:3] = acta_q;
        rd_data_o[6:5] = actb_q;
      end
      IDX_STAT: rd_data_o[2:0] = {ovf_q, fb_q, fa_q};
      IDX_CNT:  rd_data_o = cnt_q;
      IDX_CMPA: rd_data_o = cmpa_q;
      IDX_CMPB: rd_data_o = cmpb_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign cnt_o  = cnt_q;
  assign cmpa_o = cmpa_q;
  assign cmpb_o = cmpb_q;
  assign sel_o  = sel_q;
  assign pin_o  = pin_q;

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !cnt_wr && full) |=> ovf_q);

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && !inc_i) |=> $stable(cnt_q));

  // R6
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(wr_data)));

  // R5
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fa_q && !stat_wr) |=> fa_q);

  // R4
  pin_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mb_evt && actb_q == ACT_LOW) |=> !pin_q);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pkg::*; #(
  parameter int W     = 8,
  parameter int NTICK = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [3:0]       rd_addr,
  output logic [W-1:0]     rd_data,
  input  logic [NTICK-1:0] tick_i,
  output logic             tmo_hi,
  output logic             tmo_lo
);
  localparam int CW = 2 * W;

  logic [W-1:0]     hi_cnt, hi_cmpa, hi_cmpb, lo_cnt, lo_cmpa, lo_cmpb;
  logic [W-1:0]     hi_rd, lo_rd;
  logic [SEL_W-1:0] hi_sel, lo_sel;
  logic             hi_wr, lo_wr, hi_cnt_wr, lo_cnt_wr;
  logic             hi_tick, lo_tick, hi_inc, lo_inc, lo_adv, lo_full, cm_ev;
  logic             wide_ma, wide_mb, is_wide;
  logic [CW-1:0]    nxt16;
  mode_e            mode;

  assign hi_wr     = wr_en && !wr_addr[3];
  assign lo_wr     = wr_en &&  wr_addr[3];
  assign hi_cnt_wr = hi_wr && (wr_addr[2:0] == IDX_CNT);
  assign lo_cnt_wr = lo_wr && (wr_addr[2:0] == IDX_CNT);

  always_comb begin
    if (hi_sel == SEL_CHAIN)      mode = MODE_WIDE;
    else if (lo_sel == SEL_CHAIN) mode = MODE_CMCNT;
    else                          mode = MODE_SPLIT;
  end
  assign is_wide = (mode == MODE_WIDE);

  tmr_tick_pick #(.NTICK(NTICK)) u_pick_hi (.sel(hi_sel), .ticks(tick_i), .tick(hi_tick));
  tmr_tick_pick #(.NTICK(NTICK)) u_pick_lo (.sel(lo_sel), .ticks(tick_i), .tick(lo_tick));

  // Chained event from the high channel, built from its strobe and
  // compare-ahead so the low channel's increment has no path back.
  assign cm_ev   = hi_tick && !hi_cnt_wr && (W'(hi_cnt + 1'b1) == hi_cmpa);
  assign lo_inc  = (mode == MODE_CMCNT) ? cm_ev : lo_tick;
  assign lo_adv  = lo_inc && !lo_cnt_wr;
  assign lo_full = &lo_cnt;
  assign hi_inc  = is_wide ? (lo_adv && lo_full) : hi_tick;

  assign nxt16   = CW'({hi_cnt, lo_cnt} + 1'b1);
  assign wide_ma = lo_adv && (nxt16 == {hi_cmpa, lo_cmpa});
  assign wide_mb = lo_adv && (nxt16 == {hi_cmpb, lo_cmpb});

  tmr_chan #(.W(W)) u_hi (
    .clk(clk), .rst(rst), .wr_en(hi_wr), .wr_idx(wr_addr[2:0]), .wr_data(wr_data),
    .rd_idx(rd_addr[2:0]), .inc_i(hi_inc), .wide_i(is_wide),
    .wide_ma_i(wide_ma), .wide_mb_i(wide_mb),
    .cnt_o(hi_cnt), .cmpa_o(hi_cmpa), .cmpb_o(hi_cmpb), .sel_o(hi_sel),
    .pin_o(tmo_hi), .rd_data_o(hi_rd)
  );

  tmr_chan #(.W(W)) u_lo (
    .clk(clk), .rst(rst), .wr_en(lo_wr), .wr_idx(wr_addr[2:0]), .wr_data(wr_data),
    .rd_idx(rd_addr[2:0]), .inc_i(lo_inc), .wide_i(1'b0),
    .wide_ma_i(1'b0), .wide_mb_i(1'b0),
    .cnt_o(lo_cnt), .cmpa_o(lo_cmpa), .cmpb_o(lo_cmpb), .sel_o(lo_sel),
    .pin_o(tmo_lo), .rd_data_o(lo_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_addr[3] ? lo_rd : hi_rd;
  end

  // R7
  hi_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (is_wide && !(lo_adv && lo_full) && !hi_cnt_wr) |=> $stable(hi_cnt));

  // R10
  cm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CMCNT && !cm_ev && !lo_cnt_wr) |=> $stable(lo_cnt));

  // R10
  cm_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CMCNT && cm_ev && !lo_cnt_wr) |=> (lo_cnt == W'($past(lo_cnt) + 1'b1)));

  // R12
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr[2:0] > IDX_CMPB) |=> (rd_data == '0));
endmodule

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NTICK = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [3:0]       wr_addr = '0;
  logic [W-1:0]     wr_data = '0;
  logic [3:0]       rd_addr = '0;
  logic [W-1:0]     rd_data;
  logic [NTICK-1:0] tick_i = '0;
  logic             tmo_hi, tmo_lo;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  localparam logic [3:0] HI_CTRL = 4'h0, HI_STAT = 4'h1, HI_CNT = 4'h2,
                         HI_CMPA = 4'h3, HI_CMPB = 4'h4;
  localparam logic [3:0] LO_CTRL = 4'h8, LO_STAT = 4'h9, LO_CNT = 4'hA,
                         LO_CMPA = 4'hB, LO_CMPB = 4'hC;

  tmr_pair #(.W(W), .NTICK(NTICK)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_i(tick_i),
    .tmo_hi(tmo_hi), .tmo_lo(tmo_lo)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse(input int idx, input int n);
    @(negedge clk);
    tick_i[idx] = 1'b1;
    repeat (n) @(negedge clk);
    tick_i[idx] = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input int exp, input int mask);
    logic [W-1:0] v;
    rd(a, v);
    check(req, int'(v) & mask, exp & mask);
  endtask

  task automatic t_reset();
    rd_chk("R1 hi ctrl", HI_CTRL, 8'h00, 8'hFF);
    rd_chk("R1 hi stat", HI_STAT, 8'h00, 8'hFF);
    rd_chk("R1 hi cnt",  HI_CNT,  8'h00, 8'hFF);
    rd_chk("R1 hi cmpa", HI_CMPA, 8'hFF, 8'hFF);
    rd_chk("R1 hi cmpb", HI_CMPB, 8'hFF, 8'hFF);
    rd_chk("R1 lo ctrl", LO_CTRL, 8'h00, 8'hFF);
    rd_chk("R1 lo stat", LO_STAT, 8'h00, 8'hFF);
    rd_chk("R1 lo cnt",  LO_CNT,  8'h00, 8'hFF);
    rd_chk("R12 lo cmpa", LO_CMPA, 8'hFF, 8'hFF);
    rd_chk("R12 unused idx", 4'h6, 8'h00, 8'hFF);
    check("R1 pins", {tmo_hi, tmo_lo}, 0);
  endtask

  task automatic t_split();
    wr(HI_CTRL, 8'h01);
    wr(LO_CTRL, 8'h02);
    pulse(0, 5);
    rd_chk("R2 hi on tick0", HI_CNT, 5, 8'hFF);
    rd_chk("R2 lo ignores tick0", LO_CNT, 0, 8'hFF);
    pulse(1, 3);
    rd_chk("R2 lo on tick1", LO_CNT, 3, 8'hFF);
    rd_chk("R2 hi ignores tick1", HI_CNT, 5, 8'hFF);
    wr(HI_CTRL, 8'h00);
    pulse(0, 4);
    rd_chk("R2 stopped", HI_CNT, 5, 8'hFF);
    wr(LO_CTRL, 8'h05);
    pulse(3, 2);
    rd_chk("R2 code 101 uses tick3", LO_CNT, 5, 8'hFF);
  endtask

  task automatic t_wrap();
    wr(HI_CTRL, 8'h01);
    wr(HI_STAT, 8'h00);
    wr(HI_CNT, 8'hFD);
    pulse(0, 2);
    rd_chk("R3 no wrap yet", HI_STAT, 0, 8'h04);
    pulse(0, 1);
    rd_chk("R3 cnt wrapped", HI_CNT, 0, 8'hFF);
    rd_chk("R3 wrap flag", HI_STAT, 8'h04, 8'h04);
  endtask

  task automatic t_match();
    wr(HI_STAT, 8'h00);
    wr(HI_CMPA, 8'h10);
    wr(HI_CMPB, 8'h12);
    wr(HI_CTRL, 8'h31);
    wr(HI_CNT, 8'h0E);
    pulse(0, 2);
    rd_chk("R4 flag A", HI_STAT, 8'h01, 8'h03);
    check("R4 pin high on A", tmo_hi, 1);
    pulse(0, 2);
    rd_chk("R4 flag B", HI_STAT, 8'h03, 8'h03);
    check("R4 pin low on B", tmo_hi, 0);
    wr(HI_CTRL, 8'h19);
    wr(HI_CNT, 8'h0F);
    pulse(0, 1);
    check("R4 toggle", tmo_hi, 1);
    wr(HI_CMPA, 8'h20);
    wr(HI_CMPB, 8'h20);
    wr(HI_CTRL, 8'h31);
    wr(HI_CNT, 8'h1F);
    pulse(0, 1);
    check("R4 B wins same edge", tmo_hi, 0);
  endtask

  task automatic t_clear();
    wr(HI_CTRL, 8'h01);
    wr(HI_CMPA, 8'h10);
    wr(HI_STAT, 8'h07);
    rd_chk("R5 write ones keeps", HI_STAT, 8'h03, 8'h07);
    wr(HI_CNT, 8'h0F);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = HI_STAT; wr_data = 8'h00; tick_i[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_i[0] = 1'b0;
    rd_chk("R5 set beats clear", HI_STAT, 8'h01, 8'h07);
    wr(HI_STAT, 8'h00);
    rd_chk("R5 clear", HI_STAT, 8'h00, 8'h07);
  endtask

  task automatic t_load();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = HI_CNT; wr_data = 8'h40; tick_i[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_i[0] = 1'b0;
    rd_chk("R6 load no inc", HI_CNT, 8'h40, 8'hFF);
    pulse(0, 1);
    rd_chk("R6 resumes", HI_CNT, 8'h41, 8'hFF);
  endtask

  task automatic t_wide();
    wr(HI_CTRL, 8'h04);
    wr(LO_CTRL, 8'h01);
    wr(LO_CNT, 8'hFE);
    wr(HI_CNT, 8'h12);
    pulse(0, 1);
    rd_chk("R7 lo byte", LO_CNT, 8'hFF, 8'hFF);
    rd_chk("R7 hi waits", HI_CNT, 8'h12, 8'hFF);
    pulse(0, 1);
    rd_chk("R7 hi steps on lo wrap", HI_CNT, 8'h13, 8'hFF);
    rd_chk("R7 lo wrapped", LO_CNT, 8'h00, 8'hFF);
  endtask

  task automatic t_wide_match();
    wr(HI_CTRL, 8'h14);
    wr(LO_CTRL, 8'h11);
    wr(HI_CMPA, 8'h13);
    wr(LO_CMPA, 8'h05);
    wr(HI_CNT, 8'h12);
    wr(LO_CNT, 8'h03);
    wr(HI_STAT, 8'h00);
    wr(LO_STAT, 8'h00);
    pulse(0, 2);
    rd_chk("R8 lo byte match", LO_STAT, 8'h01, 8'h01);
    rd_chk("R8 no 16-bit match", HI_STAT, 8'h00, 8'h01);
    check("R11 lo pin on byte match", tmo_lo, 1);
    check("R11 hi pin idle", tmo_hi, 0);
    wr(HI_CNT, 8'h13);
    wr(LO_CNT, 8'h03);
    wr(LO_STAT, 8'h00);
    pulse(0, 2);
    rd_chk("R8 16-bit match", HI_STAT, 8'h01, 8'h01);
    rd_chk("R8 lo also", LO_STAT, 8'h01, 8'h01);
    check("R11 hi pin on 16-bit match", tmo_hi, 1);
  endtask

  task automatic t_wide_wrap();
    wr(HI_CTRL, 8'h04);
    wr(HI_CNT, 8'hFF);
    wr(LO_CNT, 8'hFE);
    wr(HI_STAT, 8'h00);
    wr(LO_STAT, 8'h00);
    pulse(0, 1);
    rd_chk("R9 no wrap at FFFF", HI_STAT, 0, 8'h04);
    pulse(0, 1);
    rd_chk("R9 16-bit wrap flag", HI_STAT, 8'h04, 8'h04);
    rd_chk("R9 hi cnt zero", HI_CNT, 0, 8'hFF);
  endtask

  task automatic t_cmcount();
    wr(HI_CTRL, 8'h01);
    wr(LO_CTRL, 8'h04);
    wr(HI_CMPA, 8'h03);
    wr(HI_CNT, 8'h00);
    wr(LO_CNT, 8'h00);
    pulse(0, 3);
    rd_chk("R10 one event", LO_CNT, 1, 8'hFF);
    pulse(0, 5);
    rd_chk("R10 holds between", LO_CNT, 1, 8'hFF);
    pulse(0, 251);
    rd_chk("R10 hi back at cmp", HI_CNT, 3, 8'hFF);
    rd_chk("R10 second event", LO_CNT, 2, 8'hFF);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_split();
    t_wrap();
    t_match();
    t_clear();
    t_load();
    t_wide();
    t_wide_match();
    t_wide_wrap();
    t_cmcount();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all) actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule